// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller places a small 8-bit microcontroller core into one of two sleep states and brings it back out. Software asks for a light sleep or a deep sleep with single-cycle request pulses. In the light sleep the CPU clock is gated off while the peripheral clocks keep running. In the deep sleep the oscillator enable is dropped as well, and every clock stops. The two states leave by different routes. The light sleep ends on any pending enabled interrupt or on the hardware reset pin. The deep sleep ends only through the reset pin. After a deep-sleep wake, the core reset is held for a programmable number of cycles so that the oscillator can settle.

In each sleep state the block also forces fixed levels on the two bus-control strobes (the address-latch strobe and the program-store strobe) and a fixed drive mode on every port. The pattern depends on whether the program runs from internal or external memory.

A reset that ends the light sleep does not reach the core at once. The core first runs for a short window, and during that window internal RAM writes are blocked. All pins are plain control and status levels. No data stream passes through the block, so no valid/ready handshake is used.

Top module: `lpm_ctrl`

## Requirements
- R1: In the running state, with `rst_pin` low, a `req_idle` pulse without `req_pdown` enters the light sleep at the next clock edge. From then `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R2: In the running state, with `rst_pin` low, a `req_pdown` pulse enters the deep sleep at the next edge, even when `req_idle` is high in the same cycle. From then `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R3: In the light sleep, with `rst_pin` low, `irq_pend` high at an edge returns the block to running. `cpu_clk_en`=1 from that edge on.
- R4: In the deep sleep, `irq_pend`, `req_idle` and `req_pdown` have no effect. `rst_pin` high at an edge sets `osc_en`=1 and `core_rst`=1 from that edge on.
- R5: After a deep-sleep wake, the edge that samples `rst_pin` low starts stabilisation. `core_rst` stays 1 for max(`stab_len`,1) cycles and is 0 afterwards.
- R6: `rst_pin` high at an edge during the light sleep opens a window of WIN_CYC cycles. In the window `cpu_clk_en`=1, `ram_inhibit`=1 and `core_rst`=0. After the window `ram_inhibit`=0 and `core_rst` follows `rst_pin`.
- R7: `strb_force`=1 with `strb_level`=1 in the light sleep. `strb_force`=1 with `strb_level`=0 in the deep sleep. `strb_force`=0 in every other state.
- R8: `port_sel` gives port n in bits [2n+1:2n]. The codes are 0 = normal, 1 = hold data latch, 2 = float, 3 = drive address. Outside the sleep states every port is 0. In either sleep state with `ext_prog`=0, every port is 1. With `ext_prog`=1, port 0 is 2 in both sleep states, port 2 is 3 in the light sleep and 1 in the deep sleep, and the other ports are 1.
- R9: While running with `rst_pin` high, `core_rst`=1 and the sleep requests are ignored.
- R10: While `rst_n` is low, the block is running with all clocks and the oscillator enabled, `core_rst`=0, `ram_inhibit`=0 and `strb_force`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Power-on reset of the controller, active low, asynchronous |
| rst_pin | input | 1 | Hardware reset pin level, active high, synchronous |
| req_idle | input | 1 | Light-sleep request pulse from software |
| req_pdown | input | 1 | Deep-sleep request pulse from software |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| ext_prog | input | 1 | 1 = program memory is external |
| stab_len | input | CNT_W | Oscillator stabilisation length in cycles |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Reset applied to the core |
| ram_inhibit | output | 1 | Blocks internal RAM writes |
| strb_force | output | 1 | Overrides both bus strobes |
| strb_level | output | 1 | Level forced on the strobes |
| port_sel | output | 2*NPORT | Per-port drive mode override |

## Verification
The reset pin can rise in the same cycle that an interrupt is pending during the light sleep. In that cycle the reset has to win and open the RAM-inhibit window rather than plainly resuming. The random phase drives `irq_pend` and `rst_pin` independently, so this overlap occurs many times. A bench-side state model judges each occurrence, and a directed run checks that both sleep requests arriving in one cycle give the deep sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RWIN  = 3'd2,
    ST_PDN   = 3'd3,
    ST_PWAKE = 3'd4,
    ST_STAB  = 3'd5
  } lpm_state_e;

  typedef enum logic [1:0] {
    PM_NORM  = 2'd0,
    PM_DATA  = 2'd1,
    PM_FLOAT = 2'd2,
    PM_ADDR  = 2'd3
  } pmode_e;
endpackage

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int WIN_CYC = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin,
  input  logic             req_idle,
  input  logic             req_pdown,
  input  logic             irq_pend,
  input  logic [CNT_W-1:0] stab_len,
  output lpm_state_e       state
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int CW    = (CNT_W > WIN_W) ? CNT_W : WIN_W;
  localparam logic [CW:0] WIN_LIM = (CW+1)'(WIN_CYC);

  lpm_state_e  st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   cnt_inc;
  logic [CW:0]   stab_ext;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign stab_ext = {{(CW+1-CNT_W){1'b0}}, stab_len};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (!rst_pin) begin
          if (req_pdown)     st_d = ST_PDN;
          else if (req_idle) st_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (rst_pin) begin
          st_d  = ST_RWIN;
          cnt_d = '0;
        end else if (irq_pend) begin
          st_d = ST_RUN;
        end
      end
      ST_RWIN: begin
        if (cnt_inc == WIN_LIM) st_d = ST_RUN;
        else                    cnt_d = cnt_inc[CW-1:0];
      end
      ST_PDN: begin
        if (rst_pin) st_d = ST_PWAKE;
      end
      ST_PWAKE: begin
        if (!rst_pin) begin
          st_d  = ST_STAB;
          cnt_d = '0;
        end
      end
      ST_STAB: begin
        if (rst_pin)                    st_d = ST_PWAKE;
        else if (cnt_inc >= stab_ext)   st_d = ST_RUN;
        else                            cnt_d = cnt_inc[CW-1:0];
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/lpm_pins.sv
module lpm_pins
  import lpm_pkg::*;
#(
  parameter int NPORT     = 4,
  parameter int MUX_PORT  = 0,
  parameter int ADDR_PORT = 2
) (
  input  lpm_state_e         state,
  input  logic               rst_pin,
  input  logic               ext_prog,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               core_rst,
  output logic               ram_inhibit,
  output logic               strb_force,
  output logic               strb_level,
  output logic [2*NPORT-1:0] port_sel
);
  logic in_idle, in_pdn, sleeping;

  assign in_idle  = (state == ST_IDLE);
  assign in_pdn   = (state == ST_PDN);
  assign sleeping = in_idle || in_pdn;

  assign cpu_clk_en    = !sleeping;
  assign periph_clk_en = !in_pdn;
  assign osc_en        = !in_pdn;
  assign ram_inhibit   = (state == ST_RWIN);
  assign core_rst      = ((state == ST_RUN) && rst_pin) ||
                         (state == ST_PWAKE) || (state == ST_STAB);
  assign strb_force    = sleeping;
  assign strb_level    = in_idle;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam bit IS_MUX  = (p == MUX_PORT);
    localparam bit IS_ADDR = (p == ADDR_PORT);
    pmode_e mode;
    always_comb begin
      mode = PM_NORM;
      if (sleeping) begin
        mode = PM_DATA;
        if (ext_prog) begin
          if (IS_MUX)                  mode = PM_FLOAT;
          else if (IS_ADDR && in_idle) mode = PM_ADDR;
        end
      end
    end
    assign port_sel[2*p +: 2] = mode;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPORT   = 4,
  parameter int CNT_W   = 8,
  parameter int WIN_CYC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pin,
  input  logic               req_idle,
  input  logic               req_pdown,
  input  logic               irq_pend,
  input  logic               ext_prog,
  input  logic [CNT_W-1:0]   stab_len,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               osc_en,
  output logic               core_rst,
  output logic               ram_inhibit,
  output logic               strb_force,
  output logic               strb_level,
  output logic [2*NPORT-1:0] port_sel
);
  lpm_state_e state;

  lpm_seq #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_idle(req_idle),
    .req_pdown(req_pdown), .irq_pend(irq_pend), .stab_len(stab_len),
    .state(state)
  );

  lpm_pins #(.NPORT(NPORT)) pins_i (
    .state(state), .rst_pin(rst_pin), .ext_prog(ext_prog),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .core_rst(core_rst), .ram_inhibit(ram_inhibit),
    .strb_force(strb_force), .strb_level(strb_level), .port_sel(port_sel)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NPORT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_pin,
  input logic               req_idle,
  input logic               req_pdown,
  input logic               irq_pend,
  input logic               ext_prog,
  input logic               cpu_clk_en,
  input logic               periph_clk_en,
  input logic               osc_en,
  input logic               core_rst,
  input logic               ram_inhibit,
  input logic               strb_force,
  input logic               strb_level,
  input logic [2*NPORT-1:0] port_sel
);
  logic running, lsleep;
  assign running = cpu_clk_en && !ram_inhibit && !core_rst;
  assign lsleep  = !cpu_clk_en && periph_clk_en;

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    running && req_idle && !req_pdown |=> !cpu_clk_en && periph_clk_en && osc_en); // R1
  AST_PDOWN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    running && req_pdown |=> !osc_en && !periph_clk_en); // R2
  AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    lsleep && irq_pend && !rst_pin |=> cpu_clk_en); // R3
  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en && !rst_pin |=> !osc_en); // R4
  AST_WIN_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ram_inhibit |-> cpu_clk_en && !core_rst); // R6
  AST_STROBE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> strb_force && (strb_level == periph_clk_en)); // R7
  AST_PORT0_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en && ext_prog |-> port_sel[1:0] == 2'd2); // R8
  AST_RUN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && !ram_inhibit && rst_pin |-> core_rst); // R9
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NPORT(NPORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_idle(req_idle),
  .req_pdown(req_pdown), .irq_pend(irq_pend), .ext_prog(ext_prog),
  .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
  .core_rst(core_rst), .ram_inhibit(ram_inhibit), .strb_force(strb_force),
  .strb_level(strb_level), .port_sel(port_sel)
);

// File: tb/lpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpm_ctrl_tb_top;
  localparam int NPORT = 4;
  localparam int CNT_W = 8;
  localparam int WIN   = 24;
  localparam int M_RUN = 0, M_IDLE = 1, M_RWIN = 2, M_PDN = 3, M_PWAKE = 4, M_STAB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin = 1'b0, req_idle = 1'b0, req_pdown = 1'b0, irq_pend = 1'b0, ext_prog = 1'b0;
  logic [CNT_W-1:0] stab_len = 8'd3;
  logic cpu_clk_en, periph_clk_en, osc_en, core_rst, ram_inhibit, strb_force, strb_level;
  logic [2*NPORT-1:0] port_sel;

  lpm_ctrl #(.NPORT(NPORT), .CNT_W(CNT_W), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .req_idle(req_idle),
    .req_pdown(req_pdown), .irq_pend(irq_pend), .ext_prog(ext_prog),
    .stab_len(stab_len), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .core_rst(core_rst), .ram_inhibit(ram_inhibit),
    .strb_force(strb_force), .strb_level(strb_level), .port_sel(port_sel)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_st = M_RUN, m_cnt = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_RUN; m_cnt = 0;
    end else begin
      case (m_st)
        M_RUN:   if (!rst_pin) begin
                   if (req_pdown) m_st = M_PDN; else if (req_idle) m_st = M_IDLE;
                 end
        M_IDLE:  if (rst_pin) begin m_st = M_RWIN; m_cnt = 0; end
                 else if (irq_pend) m_st = M_RUN;
        M_RWIN:  if (m_cnt + 1 == WIN) m_st = M_RUN; else m_cnt++;
        M_PDN:   if (rst_pin) m_st = M_PWAKE;
        M_PWAKE: if (!rst_pin) begin m_st = M_STAB; m_cnt = 0; end
        M_STAB:  if (rst_pin) m_st = M_PWAKE;
                 else if (m_cnt + 1 >= int'(stab_len)) m_st = M_RUN;
                 else m_cnt++;
        default: m_st = M_RUN;
      endcase
    end
  end

  function automatic logic [2*NPORT-1:0] exp_ports(int st, logic ext);
    logic [2*NPORT-1:0] v = '0;
    if (st == M_IDLE || st == M_PDN)
      for (int p = 0; p < NPORT; p++) begin
        logic [1:0] m = 2'd1;
        if (ext && p == 0) m = 2'd2;
        else if (ext && p == 2 && st == M_IDLE) m = 2'd3;
        v[2*p +: 2] = m;
      end
    return v;
  endfunction

  task automatic check_model();
    logic slp = (m_st == M_IDLE || m_st == M_PDN);
    chk("R1 cpu_clk_en", cpu_clk_en, !slp);
    chk("R2 periph_clk_en", periph_clk_en, m_st != M_PDN);
    chk("R2 osc_en", osc_en, m_st != M_PDN);
    chk("R5 core_rst", core_rst,
        (m_st == M_RUN && rst_pin) || m_st == M_PWAKE || m_st == M_STAB);
    chk("R6 ram_inhibit", ram_inhibit, m_st == M_RWIN);
    chk("R7 strobes", {strb_force, strb_level}, {slp, m_st == M_IDLE});
    chk("R8 port_sel", port_sel, exp_ports(m_st, ext_prog));
  endtask

  task automatic pulse_req(logic i, logic p);
    @(negedge clk); req_idle = i; req_pdown = p;
    @(negedge clk); req_idle = 0; req_pdown = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10 reset clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b111);
    chk("R10 reset core_rst/inhibit/strobe", {core_rst, ram_inhibit, strb_force}, 3'b000);
    rst_n = 1;

    // light sleep, pin patterns, interrupt exit
    pulse_req(1, 0);
    chk("R1 idle clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b011);
    chk("R7 idle strobes", {strb_force, strb_level}, 2'b11);
    chk("R8 idle internal ports", port_sel, 8'h55);
    ext_prog = 1; #1;
    chk("R8 idle external ports", port_sel, 8'h76);
    @(negedge clk); irq_pend = 1;
    @(negedge clk); irq_pend = 0;
    chk("R3 irq exit", cpu_clk_en, 1'b1);
    chk("R8 run ports", port_sel, 8'h00);
    chk("R7 run strobes", strb_force, 1'b0);

    // both requests together: deep sleep wins
    pulse_req(1, 1);
    chk("R2 priority clocks", {cpu_clk_en, periph_clk_en, osc_en}, 3'b000);
    chk("R7 pdown strobes", {strb_force, strb_level}, 2'b10);
    chk("R8 pdown external ports", port_sel, 8'h56);
    ext_prog = 0; #1;
    chk("R8 pdown internal ports", port_sel, 8'h55);
    irq_pend = 1; req_idle = 1;
    repeat (3) @(negedge clk);
    irq_pend = 0; req_idle = 0;
    chk("R4 irq ignored in pdown", osc_en, 1'b0);
    rst_pin = 1;
    @(negedge clk);
    chk("R4 reset wakes oscillator", {osc_en, core_rst}, 2'b11);
    @(negedge clk); rst_pin = 0; stab_len = 8'd3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 stab hold", core_rst, 1'b1);
    end
    @(negedge clk);
    chk("R5 stab release", core_rst, 1'b0);

    // zero stabilisation length behaves as one
    stab_len = 8'd0;
    pulse_req(0, 1);
    rst_pin = 1; @(negedge clk); rst_pin = 0;
    @(negedge clk);
    chk("R5 zero len hold", core_rst, 1'b1);
    @(negedge clk);
    chk("R5 zero len release", core_rst, 1'b0);

    // reset during light sleep, with an interrupt in the same cycle
    pulse_req(1, 0);
    rst_pin = 1; irq_pend = 1;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk); irq_pend = 0;
      chk("R6 window", {cpu_clk_en, ram_inhibit, core_rst}, 3'b110);
    end
    @(negedge clk);
    chk("R6 after window", {ram_inhibit, core_rst}, 2'b01);
    pulse_req(1, 1);
    chk("R9 requests ignored in reset", {cpu_clk_en, osc_en, core_rst}, 3'b111);
    @(negedge clk); rst_pin = 0;

    // constrained random against the bench model
    stab_len = 8'd2;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      check_model();
      req_idle  = ($urandom % 8) == 0;
      req_pdown = ($urandom % 20) == 0;
      irq_pend  = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) rst_pin = ~rst_pin;
      if (($urandom % 50) == 0) ext_prog = ~ext_prog;
      if (($urandom % 100) == 0) stab_len = CNT_W'($urandom % 6);
    end
    finish_run();
  end
endmodule